// File: doc/BRIEF.md
# Registered Two-Bus Transceiver

This block couples two 8-bit buses, called A and B, through two independent lanes. The A-to-B lane drives the B bus and the B-to-A lane drives the A bus. Each lane has a capture register, a capture strobe, a drive enable and a source choice. The source choice picks either the live value on the opposite bus or the value held in the lane's own register.

Each bus appears as three signals: an input that carries the resolved bus value, an output value and a drive enable. Everything runs on one system clock. The capture strobes arrive unsynchronised. Each strobe passes through a synchroniser and an edge detector. Each register loads its source bus on a detected rising edge, whatever the enables and source choices are doing.

The two drive enables have opposite polarity. With the A-to-B enable low and the B-to-A enable high, neither bus is driven. Driven values and drive enables leave the block through registers, so a change of source choice moves straight from the old value to the new one at a clock edge. If both lanes drive in live mode, each bus is fed from the other. Once the outside drivers let go, the pair keeps its last value.

Top module: `regbus_xcvr`

## Requirements
- R1: Synchronous active-high reset clears both capture registers, both driven values and both drive enables to zero. With both drive enables at zero, neither bus is driven.
- R2: `b_oe` equals the value that `ab_drive_en` (active high) had one clock earlier.
- R3: `a_oe` equals the inverse of the value that `ba_drive_en_n` (active low) had one clock earlier.
- R4: A source choice of 0 (live) makes the lane's driven value equal, one clock later, to the opposite bus input: `b_out` follows `a_in`, and `a_out` follows `b_in`.
- R5: A source choice of 1 (stored) makes the lane's driven value equal, one clock later, to that lane's register: `b_out` follows the A-side register, and `a_out` follows the B-side register.
- R6: A strobe level that is high at one clock edge and low at the one before it loads the register on the second clock edge after that edge. The A-side register loads `a_in` and the B-side register loads `b_in`. The load happens whatever the enables and source choices are.
- R7: A strobe held high causes exactly one load. Later changes on the source bus do not alter the register until the strobe falls and rises again.
- R8: While B is driven from the stored A register, a B-side capture loads that A value. The A value then sits in both registers.
- R9: With both lanes live and both enabled, each bus holds its value after the outside drivers release, for as long as the mode stays.
- R10: A change of source choice leaves the driven value unchanged until the next clock edge. At that edge the value moves directly to the newly selected source.
- R11: With both lanes stored and both enabled, `b_out` shows the A-side register and `a_out` shows the B-side register at the same time.
- R12: Strobes on both sides in the same cycle in live mode load both registers from their own buses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| a_in | input | WIDTH | Resolved value on the A bus |
| a_out | output | WIDTH | Value the block drives onto the A bus |
| a_oe | output | 1 | A bus drive enable |
| b_in | input | WIDTH | Resolved value on the B bus |
| b_out | output | WIDTH | Value the block drives onto the B bus |
| b_oe | output | 1 | B bus drive enable |
| ab_drive_en | input | 1 | A-to-B lane enable, active high |
| ba_drive_en_n | input | 1 | B-to-A lane enable, active low |
| ab_src | input | 1 | A-to-B source choice: 0 live, 1 stored |
| ba_src | input | 1 | B-to-A source choice: 0 live, 1 stored |
| a_cap_stb | input | 1 | A-side capture strobe, asynchronous |
| b_cap_stb | input | 1 | B-side capture strobe, asynchronous |

## Verification
Two functions can fall in the same cycle, and both cases are provoked on purpose.

The first is a B-side capture while the B bus is itself driven from the A register. The bench drives the B bus from the stored A value, pulses the B strobe, and then reads both registers back through the stored-source paths. It expects the A value in each.

The second is a source-choice change landing on a lane whose live and stored values differ. The bench changes the choice between edges. It confirms the driven value stays unchanged before the edge and equals the new source after it.

Strobes on both sides in the same cycle, with live buses, are judged the same way: each register is read back through its stored path and compared with its own bus value.

// File: rtl/regbus_xcvr_pkg.sv
package regbus_xcvr_pkg;

    typedef enum logic {
        SRC_LIVE   = 1'b0,
        SRC_STORED = 1'b1
    } src_sel_e;

    typedef struct packed {
        logic     drive;
        src_sel_e src;
    } lane_ctrl_t;

    localparam int LANE_AB   = 0;
    localparam int LANE_BA   = 1;
    localparam int NUM_LANES = 2;

    function automatic logic enable_level(input logic pin, input logic active_low);
        return active_low ? ~pin : pin;
    endfunction

    function automatic src_sel_e to_src(input logic pin);
        return pin ? SRC_STORED : SRC_LIVE;
    endfunction

endpackage

// File: rtl/xcvr_strobe_sync.sv
module xcvr_strobe_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic stb_async,
    output logic stb_rise
);
    logic [STAGES-1:0] sync_q;
    logic              last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            last_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], stb_async};
            last_q <= sync_q[STAGES-1];
        end
    end

    assign stb_rise = sync_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/xcvr_store_reg.sv
module xcvr_store_reg #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)       q <= '0;
        else if (load) q <= d;
    end
endmodule

// File: rtl/xcvr_drive_stage.sv
module xcvr_drive_stage
    import regbus_xcvr_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  lane_ctrl_t       ctrl,
    input  logic [WIDTH-1:0] live_val,
    input  logic [WIDTH-1:0] stored_val,
    output logic [WIDTH-1:0] drv_val,
    output logic             drv_oe
);
    logic [WIDTH-1:0] pick;

    always_comb begin
        unique case (ctrl.src)
            SRC_STORED: pick = stored_val;
            default:    pick = live_val;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            drv_val <= '0;
            drv_oe  <= 1'b0;
        end else begin
            drv_val <= pick;
            drv_oe  <= ctrl.drive;
        end
    end
endmodule

// File: rtl/xcvr_lane.sv
module xcvr_lane
    import regbus_xcvr_pkg::*;
#(
    parameter int WIDTH       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cap_stb,
    input  logic [WIDTH-1:0] src_bus,
    input  lane_ctrl_t       ctrl,
    output logic [WIDTH-1:0] store_q,
    output logic [WIDTH-1:0] drv_val,
    output logic             drv_oe
);
    logic cap_rise;

    xcvr_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst       (rst),
        .stb_async (cap_stb),
        .stb_rise  (cap_rise)
    );

    xcvr_store_reg #(.WIDTH(WIDTH)) u_store (
        .clk  (clk),
        .rst  (rst),
        .load (cap_rise),
        .d    (src_bus),
        .q    (store_q)
    );

    xcvr_drive_stage #(.WIDTH(WIDTH)) u_drive (
        .clk        (clk),
        .rst        (rst),
        .ctrl       (ctrl),
        .live_val   (src_bus),
        .stored_val (store_q),
        .drv_val    (drv_val),
        .drv_oe     (drv_oe)
    );
endmodule

// File: rtl/regbus_xcvr.sv
module regbus_xcvr
    import regbus_xcvr_pkg::*;
#(
    parameter int WIDTH       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] a_in,
    output logic [WIDTH-1:0] a_out,
    output logic             a_oe,
    input  logic [WIDTH-1:0] b_in,
    output logic [WIDTH-1:0] b_out,
    output logic             b_oe,
    input  logic             ab_drive_en,
    input  logic             ba_drive_en_n,
    input  logic             ab_src,
    input  logic             ba_src,
    input  logic             a_cap_stb,
    input  logic             b_cap_stb
);
    logic [WIDTH-1:0] lane_src   [NUM_LANES];
    logic [WIDTH-1:0] lane_store [NUM_LANES];
    logic [WIDTH-1:0] lane_drv   [NUM_LANES];
    logic             lane_oe    [NUM_LANES];
    logic             lane_stb   [NUM_LANES];
    lane_ctrl_t       lane_ctrl  [NUM_LANES];

    assign lane_src[LANE_AB]        = a_in;
    assign lane_src[LANE_BA]        = b_in;
    assign lane_stb[LANE_AB]        = a_cap_stb;
    assign lane_stb[LANE_BA]        = b_cap_stb;
    assign lane_ctrl[LANE_AB].drive = enable_level(ab_drive_en, 1'b0);
    assign lane_ctrl[LANE_AB].src   = to_src(ab_src);
    assign lane_ctrl[LANE_BA].drive = enable_level(ba_drive_en_n, 1'b1);
    assign lane_ctrl[LANE_BA].src   = to_src(ba_src);

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        xcvr_lane #(.WIDTH(WIDTH), .SYNC_STAGES(SYNC_STAGES)) u_lane (
            .clk     (clk),
            .rst     (rst),
            .cap_stb (lane_stb[g]),
            .src_bus (lane_src[g]),
            .ctrl    (lane_ctrl[g]),
            .store_q (lane_store[g]),
            .drv_val (lane_drv[g]),
            .drv_oe  (lane_oe[g])
        );
    end

    assign b_out = lane_drv[LANE_AB];
    assign b_oe  = lane_oe[LANE_AB];
    assign a_out = lane_drv[LANE_BA];
    assign a_oe  = lane_oe[LANE_BA];
endmodule

// File: rtl/regbus_xcvr_chk.sv
module regbus_xcvr_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst,
    input logic [WIDTH-1:0] a_in,
    input logic [WIDTH-1:0] b_in,
    input logic [WIDTH-1:0] a_out,
    input logic [WIDTH-1:0] b_out,
    input logic             a_oe,
    input logic             b_oe,
    input logic             ab_drive_en,
    input logic             ba_drive_en_n,
    input logic             ab_src,
    input logic             ba_src,
    input logic [WIDTH-1:0] store_a,
    input logic [WIDTH-1:0] store_b
);
    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (!a_oe && !b_oe && a_out == '0 && b_out == '0));

    a_r2_b_oe_active_high: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (b_oe == $past(ab_drive_en)));

    a_r3_a_oe_active_low: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (a_oe == !$past(ba_drive_en_n)));

    a_r4_ab_live: assert property (@(posedge clk) disable iff (rst)
        !ab_src |=> (b_out == $past(a_in)));

    a_r4_ba_live: assert property (@(posedge clk) disable iff (rst)
        !ba_src |=> (a_out == $past(b_in)));

    a_r5_ab_stored: assert property (@(posedge clk) disable iff (rst)
        ab_src |=> (b_out == $past(store_a)));

    a_r5_ba_stored: assert property (@(posedge clk) disable iff (rst)
        ba_src |=> (a_out == $past(store_b)));
endmodule

bind regbus_xcvr regbus_xcvr_chk #(.WIDTH(WIDTH)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .a_in          (a_in),
    .b_in          (b_in),
    .a_out         (a_out),
    .b_out         (b_out),
    .a_oe          (a_oe),
    .b_oe          (b_oe),
    .ab_drive_en   (ab_drive_en),
    .ba_drive_en_n (ba_drive_en_n),
    .ab_src        (ab_src),
    .ba_src        (ba_src),
    .store_a       (lane_store[0]),
    .store_b       (lane_store[1])
);

// File: tb/tb_regbus_xcvr.sv
module tb_regbus_xcvr;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] ext_a = '0, ext_b = '0;
    logic [W-1:0] a_out, b_out, a_bus, b_bus;
    logic         a_oe, b_oe;
    logic         ab_en = 1'b0, ba_en_n = 1'b1, ab_src = 1'b0, ba_src = 1'b0;
    logic         a_stb = 1'b0, b_stb = 1'b0;
    int           n_run = 0, n_fail = 0;
    bit           done = 1'b0;

    always #2 clk = ~clk;

    assign a_bus = a_oe ? a_out : ext_a;
    assign b_bus = b_oe ? b_out : ext_b;

    regbus_xcvr #(.WIDTH(W)) dut (
        .clk(clk), .rst(rst),
        .a_in(a_bus), .a_out(a_out), .a_oe(a_oe),
        .b_in(b_bus), .b_out(b_out), .b_oe(b_oe),
        .ab_drive_en(ab_en), .ba_drive_en_n(ba_en_n),
        .ab_src(ab_src), .ba_src(ba_src),
        .a_cap_stb(a_stb), .b_cap_stb(b_stb)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic isolate();
        ab_en = 1'b0; ba_en_n = 1'b1; ab_src = 1'b0; ba_src = 1'b0;
        tick(1);
    endtask

    task automatic pulse(input bit side_a, input bit side_b);
        if (side_a) a_stb = 1'b1;
        if (side_b) b_stb = 1'b1;
        tick(1);
        a_stb = 1'b0; b_stb = 1'b0;
        tick(3);
    endtask

    task automatic read_a_reg(output logic [W-1:0] v);
        ab_src = 1'b1; ab_en = 1'b1;
        tick(1);
        v = b_out;
    endtask

    task automatic read_b_reg(output logic [W-1:0] v);
        ba_src = 1'b1; ba_en_n = 1'b0;
        tick(1);
        v = a_out;
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] rv;
        tick(3);
        // R1 reset state
        chk("R1 a_oe", {7'd0, a_oe}, 8'd0);
        chk("R1 b_oe", {7'd0, b_oe}, 8'd0);
        chk("R1 a_out", a_out, 8'd0);
        chk("R1 b_out", b_out, 8'd0);
        rst = 1'b0;
        tick(1);
        read_a_reg(rv); chk("R1 store_a", rv, 8'd0);
        read_b_reg(rv); chk("R1 store_b", rv, 8'd0);
        isolate();

        // R2 / R3 enable polarity
        ab_en = 1'b1; tick(1); chk("R2 b_oe high", {7'd0, b_oe}, 8'd1);
        ab_en = 1'b0; tick(1); chk("R2 b_oe low", {7'd0, b_oe}, 8'd0);
        ba_en_n = 1'b0; tick(1); chk("R3 a_oe on", {7'd0, a_oe}, 8'd1);
        ba_en_n = 1'b1; tick(1); chk("R3 a_oe off", {7'd0, a_oe}, 8'd0);

        // R4 live sweep, both lanes one at a time
        ab_en = 1'b1;
        for (int v = 0; v < 256; v++) begin
            ext_a = W'(v); tick(1);
            chk("R4 a->b live", b_bus, W'(v));
        end
        isolate();
        ba_en_n = 1'b0;
        for (int v = 0; v < 256; v++) begin
            ext_b = W'(255 - v); tick(1);
            chk("R4 b->a live", a_bus, W'(255 - v));
        end
        isolate();

        // R6 / R5 capture regardless of control, read back stored
        for (int i = 0; i < 16; i++) begin
            ab_en = i[0]; ab_src = i[1]; ba_src = i[2];
            ext_a = W'(i * 17 + 3);
            ext_b = W'(i * 29 + 7);
            tick(1);
            pulse(1'b1, 1'b0);
            ba_en_n = 1'b1;
            read_a_reg(rv); chk("R6 R5 stored a", rv, W'(i * 17 + 3));
            isolate();
            pulse(1'b0, 1'b1);
            read_b_reg(rv); chk("R6 R5 stored b", rv, W'(i * 29 + 7));
            isolate();
        end

        // R6 exact load edge: strobe seen at edge k, load at edge k+2
        ext_a = 8'h9C;
        a_stb = 1'b1; ab_src = 1'b1; ab_en = 1'b1;
        tick(1); a_stb = 1'b0;
        tick(2);
        chk("R6 not yet loaded", b_out, W'(15 * 17 + 3));
        tick(1);
        chk("R6 loaded", b_out, 8'h9C);
        isolate();

        // R7 held strobe loads once
        ext_a = 8'h12; a_stb = 1'b1; tick(4);
        ext_a = 8'h34; tick(6);
        read_a_reg(rv); chk("R7 held strobe", rv, 8'h12);
        a_stb = 1'b0; isolate(); tick(3);

        // R8 B capture while B driven from stored A
        ext_a = 8'h5A; pulse(1'b1, 1'b0);
        ext_b = 8'hFF;
        ab_src = 1'b1; ab_en = 1'b1; tick(1);
        chk("R8 b bus from store", b_bus, 8'h5A);
        pulse(1'b0, 1'b1);
        read_b_reg(rv); chk("R8 store_b holds a", rv, 8'h5A);
        chk("R8 store_a kept", b_out, 8'h5A);
        isolate();

        // R11 both stored, both driven
        ext_a = 8'hA1; ext_b = 8'hB2; pulse(1'b1, 1'b1);
        ab_src = 1'b1; ba_src = 1'b1; ab_en = 1'b1; ba_en_n = 1'b0; tick(1);
        chk("R11 b_out", b_out, 8'hA1);
        chk("R11 a_out", a_out, 8'hB2);
        chk("R12 live strobes a", b_out, 8'hA1);
        chk("R12 live strobes b", a_out, 8'hB2);
        isolate();

        // R10 source change moves only at the edge
        ab_en = 1'b1; ext_a = 8'h33; tick(2);
        chk("R10 live before", b_out, 8'h33);
        ab_src = 1'b1; #1;
        chk("R10 unchanged mid", b_out, 8'h33);
        tick(1);
        chk("R10 stored after", b_out, 8'hA1);
        ab_src = 1'b0; #1;
        chk("R10 unchanged back", b_out, 8'hA1);
        tick(1);
        chk("R10 live after", b_out, 8'h33);
        isolate();

        // R9 self-holding loop
        ext_a = 8'hC3; ab_en = 1'b1; tick(1);
        ba_en_n = 1'b0; tick(1);
        ext_a = 8'h00; ext_b = 8'h00; tick(6);
        chk("R9 a holds", a_bus, 8'hC3);
        chk("R9 b holds", b_bus, 8'hC3);
        isolate();

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule